// File: doc/BRIEF.md
# Shared Slave Port Arbiter with Two-Phase Timeout Watch

Several bus masters share one slave port through this block. A round-robin arbiter picks one requester at a time. The chosen master keeps the port until the slave has both accepted its command and returned the response, so only one transaction is ever open.

Each open transaction is timed in two phases, and each phase has its own counter and its own threshold:

- **Accept phase:** the cycles spent waiting for the slave to accept the command.
- **Response phase:** the cycles spent waiting for the response after acceptance.

When a phase outlasts its threshold, the block sends a one-cycle pulse to an external error-collection unit. It also sets a sticky status bit for the master that owned the port. The master is never told about the timeout, and its transaction finishes normally.

Thresholds and status are reached through a four-word register interface. Software can raise a threshold when a slow slave causes false alarms, or write zero to switch checking off for a phase.

Top module: `slv_port_tmon`

## Requirements
- R1: When several masters request, the grant goes to the first requester found at or after the rotating pointer, counting upward and wrapping. The pointer is 0 after reset. Each grant moves the pointer to the master after the one granted.
- R2: A master holds `m_req` until it is accepted. The grant stays with that master until its response cycle. `s_req` is high only while the granted command waits for acceptance. `m_acc` and `m_rsp` are at most one-hot, and bit i of each goes only to the owning master i, in the same cycle as `s_acc` and `s_rsp` respectively.
- R3: Cycles in which `s_req` is high are numbered from 0. If the slave has not accepted by cycle T, where T is the accept threshold and T is not 0, `err_pulse` is high in the cycle after cycle T. Acceptance in cycle T or earlier gives no error.
- R4: The cycles after the accept cycle are numbered from 0. If `s_rsp` has not arrived by cycle T, where T is the response threshold and T is not 0, `err_pulse` is high in the cycle after cycle T. A response in cycle T or earlier gives no error.
- R5: Each timeout produces exactly one single-cycle `err_pulse`. Each phase raises it at most once per transaction, even when the wait goes past the counter's maximum value.
- R6: An accept-phase timeout sets bit i of the accept status word (register address 2), where i is the owning master.
- R7: A response-phase timeout sets bit i of the response status word (register address 3), where i is the owning master.
- R8: Status bits are sticky. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R9: A threshold of 0 disables timeout checking for that phase.
- R10: A timeout sends nothing back to the master. The owning master still receives `m_rsp` when the slave responds.
- R11: Register address 0 holds the accept threshold and address 1 holds the response threshold. Both reset to the value DEF_THR (default 100). Register reads are combinational.
- R12: Both phase counters start from 0 at the beginning of their phase and saturate at their maximum value instead of wrapping. With a threshold of 255 and a wait of 300 cycles, exactly one error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | NM | Request from each master, held until accepted |
| m_acc | output | NM | Acceptance returned to the owning master |
| m_rsp | output | NM | Response returned to the owning master |
| s_req | output | 1 | Command valid toward the slave |
| s_sel | output | $clog2(NM) | Index of the master owning the port |
| s_acc | input | 1 | Slave accepts the command |
| s_rsp | input | 1 | Slave returns its response |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0..3) |
| cfg_wdata | input | CW | Register write data |
| cfg_rdata | output | CW | Register read data |
| err_pulse | output | 1 | One-cycle timeout event to the error collector |

## Verification
A table of single-master transactions is run with these variations:

- Accept and response delays set exactly at a threshold, one cycle past it, and past both thresholds together. These tell an on-time handshake from a late one, and tell which of the two phases is charged.
- A threshold of zero combined with a long wait, and a threshold of 255 combined with a 300-cycle wait. These separate disabled checking from saturation, where exactly one pulse must appear.
- Simultaneous requests from all masters, and then from a subset. These expose the pointer's rotation order after earlier grants.
- Partial write-one-to-clear writes against a status word holding two set bits. These show which bits clear and which stay.

// File: rtl/spt_pkg.sv
package spt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WACC = 2'd1,
        ST_WRSP = 2'd2
    } spt_state_e;
endpackage

// File: rtl/spt_rr_pick.sv
module spt_rr_pick #(
    parameter int NM = 3,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic [NM-1:0] req,
    input  logic [IW-1:0] ptr,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        // Walk from the farthest candidate back to the pointer so the closest wins.
        for (int k = NM - 1; k >= 0; k--) begin
            int c;
            c = int'(ptr) + k;
            if (c >= NM) c = c - NM;
            if (req[c]) idx = IW'(c);
        end
    end
endmodule

// File: rtl/spt_phase_timer.sv
module spt_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [CW-1:0] thr,
    output logic          fire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fired;
        logic          fire;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        t_d.fire = 1'b0;
        if (clr) begin
            t_d.cnt   = '0;
            t_d.fired = 1'b0;
        end else if (run) begin
            if (t_q.cnt != '1) t_d.cnt = t_q.cnt + 1'b1;
            if ((thr != '0) && (t_q.cnt == thr) && !t_q.fired) begin
                t_d.fire  = 1'b1;
                t_d.fired = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign fire = t_q.fire;
endmodule

// File: rtl/slv_port_tmon.sv
module slv_port_tmon #(
    parameter int NM      = 3,
    parameter int CW      = 8,
    parameter int DEF_THR = 100,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] m_req,
    output logic [NM-1:0] m_acc,
    output logic [NM-1:0] m_rsp,
    output logic          s_req,
    output logic [IW-1:0] s_sel,
    input  logic          s_acc,
    input  logic          s_rsp,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    output logic [CW-1:0] cfg_rdata,
    output logic          err_pulse
);
    import spt_pkg::*;

    typedef struct packed {
        spt_state_e    st;
        logic [IW-1:0] own;
        logic [IW-1:0] ptr;
        logic [CW-1:0] thr_acc;
        logic [CW-1:0] thr_rsp;
        logic [NM-1:0] sts_acc;
        logic [NM-1:0] sts_rsp;
    } ctl_t;

    ctl_t r_d, r_q;

    logic          pick_any;
    logic [IW-1:0] pick_idx;
    logic          acc_fire, rsp_fire;
    logic [NM-1:0] own_oh;
    logic [NM-1:0] sts_acc_w, sts_rsp_w;

    spt_rr_pick #(.NM(NM)) u_pick (
        .req (m_req),
        .ptr (r_q.ptr),
        .any (pick_any),
        .idx (pick_idx)
    );

    spt_phase_timer #(.CW(CW)) u_tmr_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (r_q.st != ST_WACC),
        .run  ((r_q.st == ST_WACC) && !s_acc),
        .thr  (r_q.thr_acc),
        .fire (acc_fire)
    );

    spt_phase_timer #(.CW(CW)) u_tmr_rsp (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (r_q.st != ST_WRSP),
        .run  ((r_q.st == ST_WRSP) && !s_rsp),
        .thr  (r_q.thr_rsp),
        .fire (rsp_fire)
    );

    assign own_oh = NM'(1) << r_q.own;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (pick_any) begin
                    r_d.own = pick_idx;
                    r_d.ptr = (pick_idx == IW'(NM - 1)) ? '0 : pick_idx + 1'b1;
                    r_d.st  = ST_WACC;
                end
            end
            ST_WACC: if (s_acc) r_d.st = ST_WRSP;
            ST_WRSP: if (s_rsp) r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase

        if (cfg_we) begin
            unique case (cfg_addr)
                2'd0:    r_d.thr_acc = cfg_wdata;
                2'd1:    r_d.thr_rsp = cfg_wdata;
                2'd2:    r_d.sts_acc = r_q.sts_acc & ~cfg_wdata[NM-1:0];
                default: r_d.sts_rsp = r_q.sts_rsp & ~cfg_wdata[NM-1:0];
            endcase
        end

        // A timeout that lands in the same cycle as a clearing write survives it.
        if (acc_fire) r_d.sts_acc = r_d.sts_acc | own_oh;
        if (rsp_fire) r_d.sts_rsp = r_d.sts_rsp | own_oh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.thr_acc <= CW'(DEF_THR);
            r_q.thr_rsp <= CW'(DEF_THR);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (cfg_addr)
            2'd0:    cfg_rdata = r_q.thr_acc;
            2'd1:    cfg_rdata = r_q.thr_rsp;
            2'd2:    cfg_rdata = CW'(r_q.sts_acc);
            default: cfg_rdata = CW'(r_q.sts_rsp);
        endcase
    end

    assign s_req     = (r_q.st == ST_WACC);
    assign s_sel     = r_q.own;
    assign m_acc     = ((r_q.st == ST_WACC) && s_acc) ? own_oh : '0;
    assign m_rsp     = ((r_q.st == ST_WRSP) && s_rsp) ? own_oh : '0;
    assign err_pulse = acc_fire | rsp_fire;
    assign sts_acc_w = r_q.sts_acc;
    assign sts_rsp_w = r_q.sts_rsp;
endmodule

// File: rtl/spt_mon_chk.sv
module spt_mon_chk #(
    parameter int NM = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NM-1:0] m_req,
    input logic [NM-1:0] m_acc,
    input logic [NM-1:0] m_rsp,
    input logic          s_req,
    input logic          s_acc,
    input logic          s_rsp,
    input logic          err_pulse,
    input logic [NM-1:0] sts_acc,
    input logic [NM-1:0] sts_rsp
);
    // R2
    acc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_acc));
    // R2
    rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_rsp));
    // R2
    acc_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_acc & ~m_req) == '0);
    // R2
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && !s_acc) |=> s_req);
    // R10
    rsp_from_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_rsp) |-> s_rsp);
    // R5
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);
    // R6
    sts_acc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sts_acc & ~$past(sts_acc))) |-> $past(err_pulse) || err_pulse);
    // R7
    sts_rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sts_rsp & ~$past(sts_rsp))) |-> $past(err_pulse) || err_pulse);
endmodule

bind slv_port_tmon spt_mon_chk #(.NM(NM)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_req    (m_req),
    .m_acc    (m_acc),
    .m_rsp    (m_rsp),
    .s_req    (s_req),
    .s_acc    (s_acc),
    .s_rsp    (s_rsp),
    .err_pulse(err_pulse),
    .sts_acc  (sts_acc_w),
    .sts_rsp  (sts_rsp_w)
);

// File: tb/slv_port_tmon_tb.sv
module slv_port_tmon_tb;
    localparam int NM = 3;
    localparam int CW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] m_req = '0;
    logic [NM-1:0] m_acc, m_rsp;
    logic          s_req;
    logic [IW-1:0] s_sel;
    logic          s_acc = 1'b0, s_rsp = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = 2'd0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [CW-1:0] cfg_rdata;
    logic          err_pulse;

    int tests = 0, fails = 0, errs = 0, last_m = 0;

    slv_port_tmon #(.NM(NM), .CW(CW), .DEF_THR(100)) u_dut (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_acc(m_acc), .m_rsp(m_rsp),
        .s_req(s_req), .s_sel(s_sel), .s_acc(s_acc), .s_rsp(s_rsp),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .err_pulse(err_pulse)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (err_pulse) errs++;

    // {master, accept delay, response delay, accept threshold, response threshold}
    localparam int NV = 8;
    localparam int VEC [NV][5] = '{
        '{0, 0, 0, 4, 4},
        '{1, 4, 2, 4, 4},
        '{2, 5, 1, 4, 4},
        '{0, 2, 3, 6, 3},
        '{1, 1, 4, 6, 3},
        '{2, 9, 9, 0, 0},
        '{0, 7, 8, 3, 2},
        '{1, 3, 0, 3, 0}
    };

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        cfg_addr = 2'(a); cfg_wdata = CW'(d); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        cfg_addr = 2'(a);
        #1 d = int'(cfg_rdata);
    endtask

    // One transaction from master m; returns the error pulses it caused.
    task automatic txn(input int m, input int da, input int dr, output int ne);
        int e0;
        e0 = errs;
        m_req[m] = 1'b1;
        @(negedge clk);
        chk(s_req == 1'b1, "R2 s_req after grant", int'(s_req), 1);
        repeat (da) @(negedge clk);
        s_acc = 1'b1;
        #1 chk(m_acc == NM'(1 << m), "R2 accept routed to owner", int'(m_acc), 1 << m);
        @(negedge clk);
        s_acc = 1'b0; m_req[m] = 1'b0;
        repeat (dr) @(negedge clk);
        s_rsp = 1'b1;
        #1 chk(m_rsp == NM'(1 << m), "R10 response still delivered", int'(m_rsp), 1 << m);
        @(negedge clk);
        s_rsp = 1'b0;
        repeat (3) @(negedge clk);
        ne = errs - e0;
        last_m = m;
    endtask

    task automatic serve(output int who);
        while (!s_req) @(negedge clk);
        s_acc = 1'b1;
        #1 who = -1;
        for (int i = 0; i < NM; i++) if (m_acc[i]) who = i;
        @(negedge clk);
        s_acc = 1'b0;
        if (who >= 0) m_req[who] = 1'b0;
        s_rsp = 1'b1;
        @(negedge clk);
        s_rsp = 1'b0;
    endtask

    initial begin
        int d, ne, who, ea, er, exp_who;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk(s_req == 1'b0 && err_pulse == 1'b0, "R2 idle after reset", int'(s_req), 0);
        rd(0, d); chk(d == 100, "R11 accept threshold reset", d, 100);
        rd(1, d); chk(d == 100, "R11 response threshold reset", d, 100);
        rd(2, d); chk(d == 0, "R6 accept status reset", d, 0);
        rd(3, d); chk(d == 0, "R7 response status reset", d, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            wr(0, VEC[v][3]); wr(1, VEC[v][4]);
            rd(0, d); chk(d == VEC[v][3], "R11 accept threshold write", d, VEC[v][3]);
            wr(2, 'hFF); wr(3, 'hFF);
            ea = (VEC[v][3] != 0 && VEC[v][1] > VEC[v][3]) ? 1 : 0;
            er = (VEC[v][4] != 0 && VEC[v][2] > VEC[v][4]) ? 1 : 0;
            txn(VEC[v][0], VEC[v][1], VEC[v][2], ne);
            chk(ne == ea + er, "R3 R4 R9 error pulse count", ne, ea + er);
            rd(2, d); chk(d == ea * (1 << VEC[v][0]), "R6 accept status bit", d, ea * (1 << VEC[v][0]));
            rd(3, d); chk(d == er * (1 << VEC[v][0]), "R7 response status bit", d, er * (1 << VEC[v][0]));
        end

        // Round robin
        wr(0, 0); wr(1, 0);
        m_req = 3'b111;
        exp_who = (last_m + 1) % NM;
        for (int k = 0; k < 3; k++) begin
            serve(who);
            chk(who == exp_who, "R1 rotation with all requesting", who, exp_who);
            exp_who = (exp_who + 1) % NM;
        end
        m_req = 3'b011;
        serve(who);
        chk(who == 0, "R1 wrap to master 0", who, 0);
        serve(who);
        chk(who == 1, "R1 next requester", who, 1);
        repeat (2) @(negedge clk);

        // Disabled with a long wait, then saturation
        wr(0, 0);
        txn(0, 300, 0, ne);
        chk(ne == 0, "R9 zero threshold long wait", ne, 0);
        wr(0, 255);
        txn(1, 300, 0, ne);
        chk(ne == 1, "R12 R5 saturated single error", ne, 1);
        wr(1, 255);
        txn(2, 0, 300, ne);
        chk(ne == 1, "R12 R5 response saturated single", ne, 1);

        // Write-one-to-clear
        wr(0, 2); wr(1, 0); wr(2, 'hFF);
        txn(0, 4, 0, ne);
        txn(2, 4, 0, ne);
        rd(2, d); chk(d == 5, "R6 two sticky bits", d, 5);
        wr(2, 1);
        rd(2, d); chk(d == 4, "R8 write one clears", d, 4);
        wr(2, 0);
        rd(2, d); chk(d == 4, "R8 write zero keeps", d, 4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule